// File: doc/BRIEF.md
# Instruction Word Packer and Unpacker

This block narrows a stream of 24-bit instruction words to the 16-bit transfer words of a serial link with no padding bytes, and also widens such a stream back to 24-bit words. In the pack direction, two instruction words, called here the leading and the trailing word, become three transfer words. The first is the low half of the leading word. The second joins both upper bytes, with the trailing word's byte on top. The third is the low half of the trailing word. If a stream ends on a leading word, the joined word carries a zero in place of the missing upper byte and the third word is never sent.

Each direction is an independent channel with valid/ready handshakes and a last flag on both sides. Both channels pass data through combinationally in the same cycle. Each keeps only the bytes of one pending word between handshakes. A stalled output holds the input back, so no byte is lost or repeated.

Top module: `insn_word_packer`

## Requirements
- R1: For a pair of instruction words A then B, the pack output carries exactly A[15:0], then {B[23:16], A[23:16]}, then B[15:0], in that order.
- R2: When a stream ends on a leading word A (its input last is set), the pack output carries A[15:0], then {8'h00, A[23:16]} with last set, and no third transfer word.
- R3: While the pack output presents a word built only from stored bytes (the trailing low half, or the zero-padded joined word), pack input ready is low, whatever the output ready is.
- R4: Under pack output backpressure, every transfer word is delivered exactly once, and a stored-byte word stays valid and unchanged until it is accepted.
- R5: Pack output last is set only on the final transfer word of a stream, and the next input after it is treated as a leading word.
- R6: Reset returns both directions to the start of a pair: the first pack input after reset comes out as its own low half, and the first unpack input after reset produces no output word.
- R7: Unpack: transfer words L1, J, L2 produce {J[7:0], L1} together with J, then {J[15:8], L2} together with L2. Accepting L1 produces no output word.
- R8: Unpack: if last arrives on a joined word J, exactly one word {J[7:0], L1} is produced, with last set. J[15:8] is discarded, and the next transfer word is taken as a new L1.
- R9: Under unpack output backpressure, a joined or trailing transfer word is consumed only in the cycle that its output word is accepted, so every word is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pk_in_valid | input | 1 | Pack input word valid |
| pk_in_ready | output | 1 | Pack input word accepted |
| pk_in_data | input | 24 | Pack input instruction word |
| pk_in_last | input | 1 | Pack input word ends the stream |
| pk_out_valid | output | 1 | Pack transfer word valid |
| pk_out_ready | input | 1 | Pack transfer word accepted |
| pk_out_data | output | 16 | Pack transfer word |
| pk_out_last | output | 1 | Final transfer word of the stream |
| up_in_valid | input | 1 | Unpack transfer word valid |
| up_in_ready | output | 1 | Unpack transfer word accepted |
| up_in_data | input | 16 | Unpack transfer word |
| up_in_last | input | 1 | Unpack transfer word ends the stream |
| up_out_valid | output | 1 | Unpack instruction word valid |
| up_out_ready | input | 1 | Unpack instruction word accepted |
| up_out_data | output | 24 | Unpack instruction word |
| up_out_last | output | 1 | Final instruction word of the stream |

## Verification
A wrong pair phase shows at the ports on the very next transfer. A packer that is one step off puts a joined word where a low half belongs, or drops the trailing word. An unpacker that is off raises output valid on a first word, or glues the wrong upper byte. A stale stored byte shows in the next joined or trailing word, which is at most two handshakes away. A phase left over across reset or across a stream boundary is caught by the first word of the following stream.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  localparam int LO_W   = 16;
  localparam int HI_W   = 8;
  localparam int INSN_W = LO_W + HI_W;
  localparam int XFER_W = LO_W;

  // position inside a pair; shared by both directions
  typedef enum logic [1:0] {
    PH_LEAD  = 2'd0,
    PH_JOIN  = 2'd1,
    PH_TRAIL = 2'd2
  } phase_e;

  function automatic logic [LO_W-1:0] insn_low(input logic [INSN_W-1:0] w);
    return w[LO_W-1:0];
  endfunction

  function automatic logic [HI_W-1:0] insn_high(input logic [INSN_W-1:0] w);
    return w[INSN_W-1:LO_W];
  endfunction

  // second word's upper byte goes on top, first word's below
  function automatic logic [XFER_W-1:0] join_highs(input logic [HI_W-1:0] second_hi,
                                                   input logic [HI_W-1:0] first_hi);
    return {second_hi, first_hi};
  endfunction

  function automatic logic [HI_W-1:0] joined_first(input logic [XFER_W-1:0] x);
    return x[HI_W-1:0];
  endfunction

  function automatic logic [HI_W-1:0] joined_second(input logic [XFER_W-1:0] x);
    return x[XFER_W-1:XFER_W-HI_W];
  endfunction

  function automatic logic [INSN_W-1:0] build_insn(input logic [HI_W-1:0] hi,
                                                   input logic [LO_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/wpk_pack.sv
module wpk_pack
  import wpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XFER_W-1:0] out_data,
  output logic              out_last
);
  phase_e          phase_q, phase_d;
  logic [HI_W-1:0] hi_first_q;
  logic            lead_last_q;
  logic [LO_W-1:0] lo_second_q;
  logic            trail_last_q;

  // named events for the assertions
  logic in_fire, out_fire, at_lead, odd_tail, from_buf;

  always_comb begin
    at_lead  = (phase_q == PH_LEAD);
    odd_tail = (phase_q == PH_JOIN) && lead_last_q;
    from_buf = odd_tail || (phase_q == PH_TRAIL);
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    in_ready  = 1'b0;
    unique case (phase_q)
      PH_LEAD: begin
        out_valid = in_valid;
        out_data  = insn_low(in_data);
        in_ready  = out_ready;
      end
      PH_JOIN: begin
        if (lead_last_q) begin
          out_valid = 1'b1;
          out_data  = join_highs('0, hi_first_q);
          out_last  = 1'b1;
        end else begin
          out_valid = in_valid;
          out_data  = join_highs(insn_high(in_data), hi_first_q);
          in_ready  = out_ready;
        end
      end
      PH_TRAIL: begin
        out_valid = 1'b1;
        out_data  = lo_second_q;
        out_last  = trail_last_q;
      end
      default: ;
    endcase
  end

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_LEAD:  if (out_fire) phase_d = PH_JOIN;
      PH_JOIN:  if (out_fire) phase_d = lead_last_q ? PH_LEAD : PH_TRAIL;
      PH_TRAIL: if (out_fire) phase_d = PH_LEAD;
      default:  phase_d = PH_LEAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q      <= PH_LEAD;
      hi_first_q   <= '0;
      lead_last_q  <= 1'b0;
      lo_second_q  <= '0;
      trail_last_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (at_lead && in_fire) begin
        hi_first_q  <= insn_high(in_data);
        lead_last_q <= in_last;
      end
      if ((phase_q == PH_JOIN) && in_fire) begin
        lo_second_q  <= insn_low(in_data);
        trail_last_q <= in_last;
      end
    end
  end

  AST_PK_IN_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> out_fire); // R4
  AST_PK_BUF_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    from_buf |-> !in_ready); // R3
  AST_PK_BUF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    from_buf && out_valid && !out_ready |=> out_valid && $stable(out_data)); // R4
  AST_PK_LEAD_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    at_lead |-> !out_last); // R5
  AST_PK_LAST_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_last |=> at_lead); // R5
endmodule

// File: rtl/wpk_unpack.sv
module wpk_unpack
  import wpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XFER_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [INSN_W-1:0] out_data,
  output logic              out_last
);
  phase_e          phase_q, phase_d;
  logic [LO_W-1:0] lo_first_q;
  logic [HI_W-1:0] hi_second_q;

  logic in_fire, out_fire, at_lead;

  assign at_lead = (phase_q == PH_LEAD);

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    in_ready  = 1'b0;
    unique case (phase_q)
      PH_LEAD: in_ready = 1'b1;
      PH_JOIN: begin
        out_valid = in_valid;
        out_data  = build_insn(joined_first(in_data), lo_first_q);
        out_last  = in_last;
        in_ready  = out_ready;
      end
      PH_TRAIL: begin
        out_valid = in_valid;
        out_data  = build_insn(hi_second_q, in_data);
        out_last  = in_last;
        in_ready  = out_ready;
      end
      default: ;
    endcase
  end

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_LEAD:  if (in_fire) phase_d = PH_JOIN;
      PH_JOIN:  if (in_fire) phase_d = in_last ? PH_LEAD : PH_TRAIL;
      PH_TRAIL: if (in_fire) phase_d = PH_LEAD;
      default:  phase_d = PH_LEAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_LEAD;
      lo_first_q  <= '0;
      hi_second_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (at_lead && in_fire) lo_first_q <= in_data;
      if ((phase_q == PH_JOIN) && in_fire) hi_second_q <= joined_second(in_data);
    end
  end

  AST_UP_OUT_WITH_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |-> in_fire); // R9
  AST_UP_LEAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    at_lead |-> !out_valid); // R7
  AST_UP_LAST_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_last && !at_lead |=> at_lead); // R8
endmodule

// File: rtl/insn_word_packer.sv
module insn_word_packer
  import wpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pk_in_valid,
  output logic              pk_in_ready,
  input  logic [INSN_W-1:0] pk_in_data,
  input  logic              pk_in_last,
  output logic              pk_out_valid,
  input  logic              pk_out_ready,
  output logic [XFER_W-1:0] pk_out_data,
  output logic              pk_out_last,
  input  logic              up_in_valid,
  output logic              up_in_ready,
  input  logic [XFER_W-1:0] up_in_data,
  input  logic              up_in_last,
  output logic              up_out_valid,
  input  logic              up_out_ready,
  output logic [INSN_W-1:0] up_out_data,
  output logic              up_out_last
);
  wpk_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pk_in_valid),
    .in_ready  (pk_in_ready),
    .in_data   (pk_in_data),
    .in_last   (pk_in_last),
    .out_valid (pk_out_valid),
    .out_ready (pk_out_ready),
    .out_data  (pk_out_data),
    .out_last  (pk_out_last)
  );

  wpk_unpack u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (up_in_valid),
    .in_ready  (up_in_ready),
    .in_data   (up_in_data),
    .in_last   (up_in_last),
    .out_valid (up_out_valid),
    .out_ready (up_out_ready),
    .out_data  (up_out_data),
    .out_last  (up_out_last)
  );
endmodule

// File: tb/test_insn_word_packer.sv
`timescale 1ns/1ps
module test_insn_word_packer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pk_in_valid, pk_in_ready, pk_in_last;
  logic [23:0] pk_in_data;
  logic        pk_out_valid, pk_out_ready, pk_out_last;
  logic [15:0] pk_out_data;
  logic        up_in_valid, up_in_ready, up_in_last;
  logic [15:0] up_in_data;
  logic        up_out_valid, up_out_ready, up_out_last;
  logic [23:0] up_out_data;

  int total = 0;
  int fails = 0;

  logic [31:0] exp_d [64];
  logic        exp_l [64];
  logic [31:0] got_d [64];
  logic        got_l [64];
  logic [31:0] tw_d  [64];
  logic        tw_l  [64];

  always #10 clk = ~clk;

  insn_word_packer i_insn_word_packer (.*);

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  function automatic logic [23:0] gen_word(input int seed, input int i);
    return 24'(((i + 1) * 32'h0009E377) ^ (seed * 32'h00005BD1) ^ 32'h00A50F3);
  endfunction

  task automatic idle_inputs();
    pk_in_valid = 0; pk_in_data = '0; pk_in_last = 0; pk_out_ready = 0;
    up_in_valid = 0; up_in_data = '0; up_in_last = 0; up_out_ready = 0;
  endtask

  function automatic logic rdy(input int mode, input int cyc);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (cyc % 2) == 0;
    return (cyc % 3) == 2;
  endfunction

  // stream of n words through the packer, checked against the pair layout
  task automatic run_pack(input int n, input int seed, input int mode, input string ctag);
    int ne = 0, si = 0, oi = 0, cyc = 0, tail = 0;
    logic pend = 0;
    for (int i = 0; i < n; i += 2) begin
      int a = int'(gen_word(seed, i));
      exp_d[ne] = a % 65536; exp_l[ne] = 0; ne++;
      if (i + 1 < n) begin
        int b = int'(gen_word(seed, i + 1));
        exp_d[ne] = (b / 65536) * 256 + a / 65536; exp_l[ne] = 0; ne++;
        exp_d[ne] = b % 65536; exp_l[ne] = (i + 1 == n - 1); ne++;
      end else begin
        exp_d[ne] = a / 65536; exp_l[ne] = 1; ne++;
      end
    end
    while (cyc < 3000) begin
      @(negedge clk);
      if (!pend) pk_in_valid = (si < n) && (mode == 0 || (cyc % 3) != 1);
      pk_in_data   = gen_word(seed, si);
      pk_in_last   = (si == n - 1);
      pk_out_ready = rdy(mode, cyc);
      #9;
      if (pk_out_valid && pk_out_ready) begin
        if (oi < 64) begin got_d[oi] = {16'h0, pk_out_data}; got_l[oi] = pk_out_last; end
        oi++;
      end
      if (pk_in_valid && pk_in_ready) begin si++; pend = 0; end
      else pend = pk_in_valid;
      cyc++;
      if (si >= n && oi >= ne) tail++;
      if (tail >= 4) break;
    end
    pk_in_valid = 0; pk_out_ready = 0;
    chk(ctag, "pack transfer count", oi, ne);
    for (int k = 0; k < ne && k < oi; k++) begin
      chk(((n % 2) == 1 && k == ne - 1) ? "R2" : "R1", "pack data", got_d[k], exp_d[k]);
      chk("R5", "pack last", {31'h0, got_l[k]}, {31'h0, exp_l[k]});
    end
  endtask

  // stream of n instruction words, packed by the bench, through the unpacker
  task automatic run_unpack(input int n, input int seed, input int mode,
                            input logic [7:0] junk, input string ctag);
    int nt = 0, si = 0, oi = 0, cyc = 0, tail = 0;
    logic pend = 0;
    for (int i = 0; i < n; i++) begin
      exp_d[i] = {8'h0, gen_word(seed, i)}; exp_l[i] = (i == n - 1);
    end
    for (int i = 0; i < n; i += 2) begin
      int a = int'(gen_word(seed, i));
      tw_d[nt] = a % 65536; tw_l[nt] = 0; nt++;
      if (i + 1 < n) begin
        int b = int'(gen_word(seed, i + 1));
        tw_d[nt] = (b / 65536) * 256 + a / 65536; tw_l[nt] = 0; nt++;
        tw_d[nt] = b % 65536; tw_l[nt] = (i + 1 == n - 1); nt++;
      end else begin
        tw_d[nt] = int'(junk) * 256 + a / 65536; tw_l[nt] = 1; nt++;
      end
    end
    while (cyc < 3000) begin
      @(negedge clk);
      if (!pend) up_in_valid = (si < nt) && (mode == 0 || (cyc % 3) != 1);
      up_in_data   = tw_d[si < nt ? si : 0][15:0];
      up_in_last   = (si < nt) ? tw_l[si] : 1'b0;
      up_out_ready = rdy(mode, cyc);
      #9;
      if (up_out_valid && up_out_ready) begin
        if (oi < 64) begin got_d[oi] = {8'h0, up_out_data}; got_l[oi] = up_out_last; end
        oi++;
      end
      if (up_in_valid && up_in_ready) begin si++; pend = 0; end
      else pend = up_in_valid;
      cyc++;
      if (si >= nt && oi >= n) tail++;
      if (tail >= 4) break;
    end
    up_in_valid = 0; up_out_ready = 0;
    chk(ctag, "unpack word count", oi, n);
    for (int k = 0; k < n && k < oi; k++) begin
      chk(((n % 2) == 1 && k == n - 1) ? "R8" : "R7", "unpack data", got_d[k], exp_d[k]);
      chk("R7", "unpack last", {31'h0, got_l[k]}, {31'h0, exp_l[k]});
    end
  endtask

  // directed stall on the stored trailing word and the odd tail
  task automatic test_stall();
    @(negedge clk);
    pk_in_valid = 1; pk_in_data = 24'hA1B2C3; pk_in_last = 0; pk_out_ready = 1;
    #9 chk("R1", "lead low", pk_out_data, 16'hB2C3);
    @(negedge clk); pk_in_data = 24'hD4E5F6;
    #9 chk("R1", "joined", pk_out_data, 16'hD4A1);
    @(negedge clk); pk_in_data = 24'h778899; pk_in_last = 1; pk_out_ready = 0;
    #9 chk("R3", "ready while trailing held", pk_in_ready, 0);
    chk("R4", "trailing held", {pk_out_valid, pk_out_data}, {1'b1, 16'hE5F6});
    @(negedge clk);
    #9 chk("R4", "trailing still held", {pk_out_valid, pk_out_data}, {1'b1, 16'hE5F6});
    @(negedge clk); pk_out_ready = 1;
    #9 chk("R5", "trailing not last", {pk_out_data, pk_out_last}, {16'hE5F6, 1'b0});
    chk("R3", "ready with out ready", pk_in_ready, 0);
    @(negedge clk);
    #9 chk("R1", "next lead", {pk_out_data, pk_in_ready}, {16'h8899, 1'b1});
    @(negedge clk); pk_in_valid = 0;
    #9 chk("R2", "odd tail", {pk_out_valid, pk_out_data, pk_out_last}, {1'b1, 16'h0077, 1'b1});
    chk("R3", "ready during tail", pk_in_ready, 0);
    @(negedge clk);
    #9 chk("R2", "no third word", pk_out_valid, 0);
    pk_out_ready = 0; pk_in_last = 0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    pk_in_valid = 1; pk_in_data = 24'h123456; pk_in_last = 0; pk_out_ready = 1;
    up_in_valid = 1; up_in_data = 16'hBEEF; up_in_last = 0; up_out_ready = 1;
    @(negedge clk); pk_in_valid = 0; up_in_valid = 0; rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    #9 chk("R6", "pack idle after reset", pk_out_valid, 0);
    chk("R6", "unpack idle after reset", up_out_valid, 0);
    @(negedge clk);
    pk_in_valid = 1; pk_in_data = 24'hABCDEF;
    up_in_valid = 1; up_in_data = 16'h7777;
    #9 chk("R6", "pack lead after reset", {pk_out_data, pk_out_last}, {16'hCDEF, 1'b0});
    chk("R6", "unpack lead silent", {up_out_valid, up_in_ready}, {1'b0, 1'b1});
    @(negedge clk);
    pk_in_data = 24'h010203; pk_in_last = 1;
    up_in_data = 16'h4455; up_in_last = 1;
    #9 chk("R6", "pack joined after reset", pk_out_data, 16'h01AB);
    chk("R8", "unpack short pair", {up_out_valid, up_out_data, up_out_last}, {1'b1, 24'h557777, 1'b1});
    @(negedge clk); pk_in_valid = 0; up_in_valid = 0;
    #9 chk("R5", "pack final", {pk_out_data, pk_out_last}, {16'h0203, 1'b1});
    chk("R8", "unpack back to lead", up_out_valid, 0);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #4_000_000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #9 chk("R6", "reset pack valid", pk_out_valid, 0);
    chk("R6", "reset unpack valid", up_out_valid, 0);
    test_stall();
    run_pack(4, 1, 0, "R1");
    run_pack(5, 2, 0, "R2");
    run_pack(7, 3, 1, "R4");
    run_pack(6, 4, 2, "R4");
    run_pack(1, 5, 2, "R2");
    test_reset();
    run_unpack(4, 6, 0, 8'h00, "R7");
    run_unpack(5, 7, 0, 8'hA5, "R8");
    run_unpack(6, 8, 1, 8'h00, "R9");
    run_unpack(3, 9, 2, 8'h3C, "R9");
    summary();
    $finish;
  end
endmodule